// File: doc/BRIEF.md
# PCI Configuration Access Engine

This block serves configuration reads and writes for a host-side PCI bridge. A requester hands it one request at a time: a bus number, device, function, register offset, access size and write data. The engine maps the request onto a memory-mapped configuration window. Every window access is a 32-bit word. Before each access, the engine places the target bus number in a field of its control register. It converts between host byte order and little-endian bus order. It turns a master abort into an all-ones result and then clears the abort. Writes narrower than a word are carried out as a read-modify-write of the containing word.

Bus 0 is special. On that bus, device numbers are moved up by six slots, so device 0 is selected on AD16. A reserved bus code reaches the bridge's own configuration header. Requests that name a device or bus outside the 0..15 range are completed at once, with no window traffic.

Top module: `pcicfg_engine`

## Requirements
- R1: Each window access uses address `WIN_BASE | (devfn << 8) | (offset & 0xFC)`. Here devfn is `dev*8 + fn`, after the adjustments in R3 and R4, and its bits 1:0 are always zero.
- R2: Before each window access, `ctrl_o[26:23]` holds the low four bits of the effective bus number. All other bits of `ctrl_o` keep their `CTRL_INIT` value.
- R3: On bus 0, 48 is added to devfn, so device 0 function 0 produces window address bits 15:8 = 0x30.
- R4: Bus code `BRIDGE_BUS` (default 256) targets the bridge. The access is made as bus 0 with devfn 0, and the 48 shift is not applied.
- R5: A request is out of range when its device is above 15, or its bus is above 15 and is not the bridge code. Such a request makes no window access and completes without error. A read of this kind returns 0xFFFFFFFF at any size.
- R6: If a read returns with the abort flag set, the engine writes to the bridge at offset 0x04, with bus field 0 and data `cmdstat_i` byte-reversed. The requested field then reads as all ones: 0xFFFFFFFF, 0x0000FFFF or 0x000000FF.
- R7: Data is byte-reversed in both directions between the host and the window. Host word 0xCAFEF00D is stored on the window as 0x0DF0FECA.
- R8: Size encoding is 0 = byte, 1 = halfword, 2 = word. A byte or halfword read returns the word shifted right by `8*(offset%4)` and masked to its width.
- R9: A byte or halfword write first reads the containing word. It then merges the new field at shift `8*(offset%4)` and writes the whole word back. After an aborted read, the merge starts from 0xFFFFFFFF.
- R10: The request completes with error, read data 0 and no window access in three cases: a word request whose offset is not a multiple of 4, a halfword request at an odd offset, or size code 3.
- R11: `req_ready_o` is high only while idle, and only one request is in flight. `rsp_done_o` is a single-cycle pulse. A window request stays asserted with a stable address until `win_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Engine idle, request accepted |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bus_i | input | BUS_W | Bus number or bridge code |
| req_dev_i | input | DEV_W | Device number |
| req_fn_i | input | 3 | Function number |
| req_off_i | input | 8 | Register byte offset |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| req_wdata_i | input | 32 | Write data, right-aligned |
| rsp_done_o | output | 1 | Completion pulse |
| rsp_err_o | output | 1 | Request rejected (valid with done) |
| rsp_rdata_o | output | 32 | Read result (valid with done) |
| win_req_o | output | 1 | Window access request |
| win_we_o | output | 1 | Window write |
| win_addr_o | output | 32 | Window word address |
| win_wdata_o | output | 32 | Window write data, bus order |
| win_ack_i | input | 1 | Window access complete |
| win_rdata_i | input | 32 | Window read data, bus order |
| win_abort_i | input | 1 | Master abort on the acknowledged read |
| cmdstat_i | input | 32 | Command/status word rewritten to clear an abort |
| ctrl_o | output | 32 | Control register carrying the bus field |

## Verification
The bench builds the engine with `WIN_BASE = 0x90030000` and `CTRL_INIT = 0x00002105`. The non-zero low bits of `CTRL_INIT` show whether the bus-field update preserves its neighbours. The non-default base shows whether address formation ORs the base in rather than using a constant. The window model answers after three cycles. This keeps the engine in its wait states long enough to observe the ready and hold behaviour. It also gives a dependent read, abort-clear and write sequence several cycles between steps. The model aborts reads to one chosen devfn, which makes the abort-clear path and the read-modify-write-after-abort path reachable.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_CLR,
    S_WR,
    S_DONE
  } seq_st_e;

  function automatic logic [31:0] swap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/pcicfg_addr_gen.sv
module pcicfg_addr_gen #(
  parameter logic [31:0] WIN_BASE   = 32'h4001_0000,
  parameter int          BUS_W      = 9,
  parameter int          DEV_W      = 5,
  parameter int          BRIDGE_BUS = 256,
  parameter int          DEV_SHIFT  = 48
) (
  input  logic [BUS_W-1:0] bus_i,
  input  logic [DEV_W-1:0] dev_i,
  input  logic [2:0]       fn_i,
  input  logic [7:0]       off_i,
  output logic [31:0]      addr_o,
  output logic [3:0]       bus_fld_o,
  output logic             in_range_o
);
  localparam int MAX_IDX = 15;

  logic       is_bridge;
  logic       bus_ok, dev_ok;
  logic [7:0] devfn_raw, devfn;

  assign is_bridge = (int'(bus_i) == BRIDGE_BUS);
  assign bus_ok    = (int'(bus_i) <= MAX_IDX);
  assign dev_ok    = (int'(dev_i) <= MAX_IDX);
  assign in_range_o = dev_ok && (bus_ok || is_bridge);

  assign devfn_raw = {1'b0, dev_i[3:0], fn_i};

  always_comb begin
    if (is_bridge)           devfn = 8'd0;
    else if (bus_i == '0)    devfn = devfn_raw + 8'(DEV_SHIFT);
    else                     devfn = devfn_raw;
  end

  assign bus_fld_o = is_bridge ? 4'd0 : bus_i[3:0];
  assign addr_o    = WIN_BASE | {16'h0, devfn, off_i & 8'hFC};
endmodule

// File: rtl/pcicfg_lane.sv
module pcicfg_lane (
  input  logic [31:0] word_i,
  input  logic [31:0] new_i,
  input  logic [1:0]  off_i,
  input  logic [1:0]  size_i,
  output logic [31:0] field_o,
  output logic [31:0] merged_o
);
  import pcicfg_pkg::*;

  logic [4:0]  sh;
  logic [31:0] keep;

  assign sh = {off_i, 3'b000};

  always_comb begin
    case (size_e'(size_i))
      SZ_BYTE: keep = 32'h0000_00FF;
      SZ_HALF: keep = 32'h0000_FFFF;
      default: keep = 32'hFFFF_FFFF;
    endcase
  end

  assign field_o  = (word_i >> sh) & keep;
  assign merged_o = (word_i & ~(keep << sh)) | ((new_i & keep) << sh);
endmodule

// File: rtl/pcicfg_seq.sv
module pcicfg_seq #(
  parameter logic [31:0] WIN_BASE  = 32'h4001_0000,
  parameter logic [31:0] CTRL_INIT = 32'h0000_2000,
  parameter int          BUS_LSB   = 23,
  parameter logic [7:0]  CLR_OFF   = 8'h04
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        req_write_i,
  input  logic [1:0]  req_size_i,
  input  logic [1:0]  req_off_lo_i,
  input  logic [31:0] req_wdata_i,
  input  logic [31:0] tgt_addr_i,
  input  logic [3:0]  tgt_bus_i,
  input  logic        tgt_ok_i,
  input  logic [31:0] merged_i,
  input  logic [31:0] cmdstat_i,
  input  logic        win_ack_i,
  input  logic [31:0] win_rdata_i,
  input  logic        win_abort_i,
  output logic        req_ready_o,
  output logic        done_o,
  output logic        err_o,
  output logic        ones_o,
  output logic        write_o,
  output logic [31:0] word_o,
  output logic [31:0] wdata_o,
  output logic [1:0]  off_lo_o,
  output logic [1:0]  size_o,
  output logic        win_req_o,
  output logic        win_we_o,
  output logic [31:0] win_addr_o,
  output logic [31:0] win_wdata_o,
  output logic [31:0] ctrl_o
);
  import pcicfg_pkg::*;

  localparam int          FLD_W    = 4;
  localparam logic [31:0] CLR_ADDR = WIN_BASE | {24'h0, CLR_OFF};

  seq_st_e     st_q;
  logic [31:0] addr_q, word_q, wdata_q, ctrl_q;
  logic [3:0]  bus_q;
  logic [1:0]  size_q, off_q;
  logic        write_q, err_q, ones_q;
  logic        bad_align;

  always_comb begin
    case (size_e'(req_size_i))
      SZ_WORD: bad_align = (req_off_lo_i != 2'd0);
      SZ_HALF: bad_align = req_off_lo_i[0];
      SZ_BYTE: bad_align = 1'b0;
      default: bad_align = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      addr_q  <= '0;
      word_q  <= '0;
      wdata_q <= '0;
      ctrl_q  <= CTRL_INIT;
      bus_q   <= '0;
      size_q  <= '0;
      off_q   <= '0;
      write_q <= 1'b0;
      err_q   <= 1'b0;
      ones_q  <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (req_valid_i) begin
          addr_q  <= tgt_addr_i;
          bus_q   <= tgt_bus_i;
          size_q  <= req_size_i;
          off_q   <= req_off_lo_i;
          write_q <= req_write_i;
          wdata_q <= req_wdata_i;
          word_q  <= req_wdata_i;
          err_q   <= 1'b0;
          ones_q  <= 1'b0;
          if (!tgt_ok_i) begin
            ones_q <= !req_write_i;
            st_q   <= S_DONE;
          end else if (bad_align) begin
            err_q <= 1'b1;
            st_q  <= S_DONE;
          end else begin
            ctrl_q[BUS_LSB +: FLD_W] <= tgt_bus_i;
            st_q <= (req_write_i && size_e'(req_size_i) == SZ_WORD) ? S_WR : S_RD;
          end
        end
        S_RD: if (win_ack_i) begin
          if (win_abort_i) begin
            word_q <= 32'hFFFF_FFFF;
            ctrl_q[BUS_LSB +: FLD_W] <= '0;
            st_q   <= S_CLR;
          end else begin
            word_q <= swap32(win_rdata_i);
            st_q   <= write_q ? S_WR : S_DONE;
          end
        end
        S_CLR: if (win_ack_i) begin
          if (write_q) begin
            ctrl_q[BUS_LSB +: FLD_W] <= bus_q;
            st_q <= S_WR;
          end else begin
            st_q <= S_DONE;
          end
        end
        S_WR:    if (win_ack_i) st_q <= S_DONE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == S_IDLE);
  assign done_o      = (st_q == S_DONE);
  assign err_o       = err_q;
  assign ones_o      = ones_q;
  assign write_o     = write_q;
  assign word_o      = word_q;
  assign wdata_o     = wdata_q;
  assign off_lo_o    = off_q;
  assign size_o      = size_q;
  assign ctrl_o      = ctrl_q;

  assign win_req_o   = (st_q == S_RD) || (st_q == S_CLR) || (st_q == S_WR);
  assign win_we_o    = (st_q == S_CLR) || (st_q == S_WR);
  assign win_addr_o  = (st_q == S_CLR) ? CLR_ADDR : addr_q;
  assign win_wdata_o = (st_q == S_CLR) ? swap32(cmdstat_i) : swap32(merged_i);
endmodule

// File: rtl/pcicfg_engine.sv
module pcicfg_engine #(
  parameter logic [31:0] WIN_BASE   = 32'h4001_0000,
  parameter logic [31:0] CTRL_INIT  = 32'h0000_2000,
  parameter int          BUS_W      = 9,
  parameter int          DEV_W      = 5,
  parameter int          BRIDGE_BUS = 256,
  parameter int          DEV_SHIFT  = 48,
  parameter int          BUS_LSB    = 23,
  parameter logic [7:0]  CLR_OFF    = 8'h04
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic [BUS_W-1:0] req_bus_i,
  input  logic [DEV_W-1:0] req_dev_i,
  input  logic [2:0]       req_fn_i,
  input  logic [7:0]       req_off_i,
  input  logic [1:0]       req_size_i,
  input  logic [31:0]      req_wdata_i,
  output logic             rsp_done_o,
  output logic             rsp_err_o,
  output logic [31:0]      rsp_rdata_o,
  output logic             win_req_o,
  output logic             win_we_o,
  output logic [31:0]      win_addr_o,
  output logic [31:0]      win_wdata_o,
  input  logic             win_ack_i,
  input  logic [31:0]      win_rdata_i,
  input  logic             win_abort_i,
  input  logic [31:0]      cmdstat_i,
  output logic [31:0]      ctrl_o
);
  logic [31:0] tgt_addr, merged, field, word, wdata;
  logic [3:0]  tgt_bus;
  logic        tgt_ok, done, err, ones, write;
  logic [1:0]  off_lo, size;

  pcicfg_addr_gen #(
    .WIN_BASE(WIN_BASE), .BUS_W(BUS_W), .DEV_W(DEV_W),
    .BRIDGE_BUS(BRIDGE_BUS), .DEV_SHIFT(DEV_SHIFT)
  ) u_addr (
    .bus_i(req_bus_i), .dev_i(req_dev_i), .fn_i(req_fn_i), .off_i(req_off_i),
    .addr_o(tgt_addr), .bus_fld_o(tgt_bus), .in_range_o(tgt_ok)
  );

  pcicfg_lane u_lane (
    .word_i(word), .new_i(wdata), .off_i(off_lo), .size_i(size),
    .field_o(field), .merged_o(merged)
  );

  pcicfg_seq #(
    .WIN_BASE(WIN_BASE), .CTRL_INIT(CTRL_INIT), .BUS_LSB(BUS_LSB), .CLR_OFF(CLR_OFF)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_size_i(req_size_i), .req_off_lo_i(req_off_i[1:0]), .req_wdata_i(req_wdata_i),
    .tgt_addr_i(tgt_addr), .tgt_bus_i(tgt_bus), .tgt_ok_i(tgt_ok),
    .merged_i(merged), .cmdstat_i(cmdstat_i),
    .win_ack_i(win_ack_i), .win_rdata_i(win_rdata_i), .win_abort_i(win_abort_i),
    .req_ready_o(req_ready_o), .done_o(done), .err_o(err), .ones_o(ones),
    .write_o(write), .word_o(word), .wdata_o(wdata), .off_lo_o(off_lo), .size_o(size),
    .win_req_o(win_req_o), .win_we_o(win_we_o), .win_addr_o(win_addr_o),
    .win_wdata_o(win_wdata_o), .ctrl_o(ctrl_o)
  );

  assign rsp_done_o  = done;
  assign rsp_err_o   = done && err;
  assign rsp_rdata_o = (!done || err || write) ? 32'h0 :
                       ones ? 32'hFFFF_FFFF : field;
endmodule

// File: rtl/pcicfg_engine_chk.sv
module pcicfg_engine_chk #(
  parameter logic [31:0] WIN_BASE  = 32'h4001_0000,
  parameter int          BUS_LSB   = 23,
  parameter logic [7:0]  CLR_OFF   = 8'h04
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_ready_o,
  input logic        rsp_done_o,
  input logic        rsp_err_o,
  input logic [31:0] rsp_rdata_o,
  input logic        win_req_o,
  input logic        win_we_o,
  input logic [31:0] win_addr_o,
  input logic        win_ack_i,
  input logic        win_abort_i,
  input logic [31:0] ctrl_o
);
  localparam logic [31:0] FLD_MASK = 32'hF << BUS_LSB;

  // R11
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !win_req_o && !rsp_done_o);

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o);

  // R11
  win_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_req_o && !win_ack_i |=> win_req_o && $stable(win_addr_o) && $stable(win_we_o));

  // R10
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> rsp_done_o && rsp_rdata_o == 32'h0);

  // R2
  ctrl_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(ctrl_o & ~FLD_MASK));

  // R1
  win_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_req_o |-> win_addr_o[1:0] == 2'b00 && (win_addr_o & 32'hFFFF_0000) == WIN_BASE);

  // R6
  abort_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_req_o && !win_we_o && win_ack_i && win_abort_i |=>
      win_req_o && win_we_o && win_addr_o == (WIN_BASE | {24'h0, CLR_OFF})
      && ctrl_o[BUS_LSB +: 4] == 4'd0);
endmodule

bind pcicfg_engine pcicfg_engine_chk #(
  .WIN_BASE(WIN_BASE), .BUS_LSB(BUS_LSB), .CLR_OFF(CLR_OFF)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_o(req_ready_o),
  .rsp_done_o(rsp_done_o), .rsp_err_o(rsp_err_o), .rsp_rdata_o(rsp_rdata_o),
  .win_req_o(win_req_o), .win_we_o(win_we_o), .win_addr_o(win_addr_o),
  .win_ack_i(win_ack_i), .win_abort_i(win_abort_i), .ctrl_o(ctrl_o)
);

// File: tb/pcicfg_engine_test.sv
module pcicfg_engine_test;
  localparam logic [31:0] BASE  = 32'h9003_0000;
  localparam logic [31:0] CINIT = 32'h0000_2105;
  localparam int          LAT   = 3;
  localparam logic [31:0] CMDST = 32'h0280_0146;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        valid = 1'b0, ready, write = 1'b0;
  logic [8:0]  bus = '0;
  logic [4:0]  dev = '0;
  logic [2:0]  fn = '0;
  logic [7:0]  off = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic        done, err;
  logic [31:0] rdata;
  logic        win_req, win_we, win_ack, win_abort;
  logic [31:0] win_addr, win_wdata, win_rdata, ctrl;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  pcicfg_engine #(.WIN_BASE(BASE), .CTRL_INIT(CINIT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_write_i(write), .req_bus_i(bus), .req_dev_i(dev), .req_fn_i(fn),
    .req_off_i(off), .req_size_i(size), .req_wdata_i(wdata),
    .rsp_done_o(done), .rsp_err_o(err), .rsp_rdata_o(rdata),
    .win_req_o(win_req), .win_we_o(win_we), .win_addr_o(win_addr),
    .win_wdata_o(win_wdata), .win_ack_i(win_ack), .win_rdata_i(win_rdata),
    .win_abort_i(win_abort), .cmdstat_i(CMDST), .ctrl_o(ctrl)
  );

  // window model: fixed latency, aborts reads to one devfn
  logic [31:0] mem [logic [31:0]];
  int          cnt = 0, acc = 0, wr_n = 0;
  logic        abort_on = 1'b0;
  logic [7:0]  abort_devfn = 8'h00;
  logic [31:0] last_rd_addr = '0, last_wr_addr = '0, last_wr_data = '0;
  logic [3:0]  last_rd_fld = '0, last_wr_fld = '0;

  function automatic logic [31:0] sw(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_ack <= 1'b0; win_abort <= 1'b0; win_rdata <= '0; cnt <= 0;
    end else if (win_ack) begin
      win_ack <= 1'b0; win_abort <= 1'b0; cnt <= 0;
    end else if (win_req) begin
      if (cnt == LAT - 1) begin
        win_ack <= 1'b1;
        acc <= acc + 1;
        if (win_we) begin
          mem[win_addr] = win_wdata;
          wr_n <= wr_n + 1;
          last_wr_addr <= win_addr; last_wr_data <= win_wdata;
          last_wr_fld <= ctrl[26:23];
        end else begin
          win_abort <= abort_on && (win_addr[15:8] == abort_devfn);
          win_rdata <= mem.exists(win_addr) ? mem[win_addr] : 32'h0;
          last_rd_addr <= win_addr; last_rd_fld <= ctrl[26:23];
        end
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_req(input bit w, input logic [8:0] b, input logic [4:0] d, input logic [2:0] f,
                        input logic [7:0] o, input logic [1:0] s, input logic [31:0] wd,
                        output logic [31:0] rd, output logic er);
    @(negedge clk);
    write = w; bus = b; dev = d; fn = f; off = o; size = s; wdata = wd; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    while (!done) @(negedge clk);
    rd = rdata; er = err;
    @(negedge clk);
    chk(!done && ready, "R11 done pulse/ready", {30'b0, done, ready}, 32'h1);
  endtask

  task automatic t_reset;
    chk(ready == 1'b1 && done == 1'b0 && win_req == 1'b0, "R11 reset idle", {29'b0, ready, done, win_req}, 32'h4);
    chk(ctrl == CINIT, "R2 reset ctrl", ctrl, CINIT);
  endtask

  task automatic t_word_read;
    logic [31:0] r; logic e;
    mem[BASE | 32'h1910] = sw(32'h1122_3344);
    do_req(0, 9'd2, 5'd3, 3'd1, 8'h10, 2'd2, 0, r, e);
    chk(r == 32'h1122_3344 && !e, "R7 word read swap", r, 32'h1122_3344);
    chk(last_rd_addr == (BASE | 32'h1910), "R1 read address", last_rd_addr, BASE | 32'h1910);
    chk(last_rd_fld == 4'd2, "R2 bus field", {28'b0, last_rd_fld}, 32'd2);
    chk((ctrl & ~(32'hF << 23)) == CINIT, "R2 other ctrl bits", ctrl, CINIT);
  endtask

  task automatic t_bus0;
    logic [31:0] r; logic e;
    mem[BASE | 32'h4320] = sw(32'hA5A5_0001);
    do_req(0, 9'd0, 5'd2, 3'd3, 8'h21, 2'd0, 0, r, e);
    chk(last_rd_addr == (BASE | 32'h4320), "R3 bus0 shift", last_rd_addr, BASE | 32'h4320);
    chk(r == 32'h0000_0000 + 8'h00 && !e, "R8 byte at off1", r, 32'h0);
    chk(last_rd_fld == 4'd0, "R2 bus0 field", {28'b0, last_rd_fld}, 0);
  endtask

  task automatic t_bridge;
    logic [31:0] r; logic e;
    mem[BASE | 32'h000C] = sw(32'h00FF_4008);
    do_req(0, 9'd5, 5'd1, 3'd0, 8'h00, 2'd2, 0, r, e);
    do_req(0, 9'd256, 5'd7, 3'd2, 8'h0C, 2'd2, 0, r, e);
    chk(last_rd_addr == (BASE | 32'h000C), "R4 bridge address", last_rd_addr, BASE | 32'h000C);
    chk(last_rd_fld == 4'd0, "R4 bridge bus field", {28'b0, last_rd_fld}, 0);
    chk(r == 32'h00FF_4008, "R4 bridge read", r, 32'h00FF_4008);
  endtask

  task automatic t_range;
    logic [31:0] r; logic e; int a0;
    a0 = acc;
    do_req(0, 9'd1, 5'd16, 3'd0, 8'h00, 2'd2, 0, r, e);
    chk(r == 32'hFFFF_FFFF && !e, "R5 dev>15 read", r, 32'hFFFF_FFFF);
    do_req(0, 9'd16, 5'd0, 3'd0, 8'h02, 2'd1, 0, r, e);
    chk(r == 32'hFFFF_FFFF && !e, "R5 bus>15 half read", r, 32'hFFFF_FFFF);
    do_req(1, 9'd20, 5'd0, 3'd0, 8'h00, 2'd2, 32'h1234, r, e);
    chk(!e, "R5 write no error", {31'b0, e}, 0);
    chk(acc == a0, "R5 no window access", acc, a0);
  endtask

  task automatic t_abort;
    logic [31:0] r; logic e; int w0;
    abort_on = 1'b1; abort_devfn = 8'h28;
    w0 = wr_n;
    do_req(0, 9'd1, 5'd5, 3'd0, 8'h08, 2'd2, 0, r, e);
    chk(r == 32'hFFFF_FFFF && !e, "R6 abort word", r, 32'hFFFF_FFFF);
    chk(last_wr_addr == (BASE | 32'h0004) && wr_n == w0 + 1, "R6 clear address", last_wr_addr, BASE | 32'h0004);
    chk(last_wr_data == 32'h4601_8002, "R6 clear data", last_wr_data, 32'h4601_8002);
    chk(last_wr_fld == 4'd0, "R6 clear bus field", {28'b0, last_wr_fld}, 0);
    do_req(0, 9'd1, 5'd5, 3'd0, 8'h0A, 2'd0, 0, r, e);
    chk(r == 32'h0000_00FF, "R6 abort byte", r, 32'hFF);
    w0 = wr_n;
    do_req(1, 9'd1, 5'd5, 3'd0, 8'h00, 2'd0, 32'h0, r, e);
    chk(wr_n == w0 + 2 && last_wr_addr == (BASE | 32'h2800), "R9 write after abort", last_wr_addr, BASE | 32'h2800);
    chk(last_wr_data == sw(32'hFFFF_FF00), "R9 merge on ones", last_wr_data, sw(32'hFFFF_FF00));
    chk(last_wr_fld == 4'd1, "R2 field restored", {28'b0, last_wr_fld}, 1);
    abort_on = 1'b0;
  endtask

  task automatic t_narrow;
    logic [31:0] r; logic e;
    mem[BASE | 32'h0840] = sw(32'hA1B2_C3D4);
    do_req(0, 9'd3, 5'd1, 3'd0, 8'h43, 2'd0, 0, r, e);
    chk(r == 32'hA1, "R8 byte off3", r, 32'hA1);
    do_req(0, 9'd3, 5'd1, 3'd0, 8'h41, 2'd0, 0, r, e);
    chk(r == 32'hC3, "R8 byte off1", r, 32'hC3);
    do_req(0, 9'd3, 5'd1, 3'd0, 8'h42, 2'd1, 0, r, e);
    chk(r == 32'hA1B2, "R8 half off2", r, 32'hA1B2);
    do_req(1, 9'd3, 5'd1, 3'd0, 8'h41, 2'd0, 32'hFFFF_FF5A, r, e);
    chk(mem[BASE | 32'h0840] == 32'hD45A_B2A1, "R9 byte rmw", mem[BASE | 32'h0840], 32'hD45A_B2A1);
    do_req(1, 9'd3, 5'd1, 3'd0, 8'h42, 2'd1, 32'h0000_BEEF, r, e);
    chk(mem[BASE | 32'h0840] == 32'hD45A_EFBE, "R9 half rmw", mem[BASE | 32'h0840], 32'hD45A_EFBE);
    do_req(1, 9'd4, 5'd2, 3'd0, 8'h18, 2'd2, 32'hCAFE_F00D, r, e);
    chk(mem[BASE | 32'h1018] == 32'h0DF0_FECA, "R7 word write swap", mem[BASE | 32'h1018], 32'h0DF0_FECA);
  endtask

  task automatic t_align;
    logic [31:0] r; logic e; int a0;
    a0 = acc;
    do_req(0, 9'd3, 5'd1, 3'd0, 8'h42, 2'd2, 0, r, e);
    chk(e && r == 0, "R10 word misaligned", {31'b0, e}, 1);
    do_req(1, 9'd3, 5'd1, 3'd0, 8'h43, 2'd1, 32'h1, r, e);
    chk(e, "R10 half odd", {31'b0, e}, 1);
    do_req(0, 9'd3, 5'd1, 3'd0, 8'h40, 2'd3, 0, r, e);
    chk(e, "R10 size code 3", {31'b0, e}, 1);
    chk(acc == a0, "R10 no access", acc, a0);
    do_req(0, 9'd3, 5'd1, 3'd0, 8'h43, 2'd0, 0, r, e);
    chk(!e && r == 32'hBE, "R10 byte any offset", r, 32'hBE);
  endtask

  task automatic t_busy;
    @(negedge clk);
    write = 0; bus = 9'd2; dev = 5'd3; fn = 3'd1; off = 8'h10; size = 2'd2; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    @(negedge clk);
    chk(!ready && win_req, "R11 busy not ready", {30'b0, ready, win_req}, 32'h1);
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(ready, "R11 idle again", {31'b0, ready}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word_read();
    t_bus0();
    t_bridge();
    t_range();
    t_abort();
    t_narrow();
    t_align();
    t_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule